// File: doc/BRIEF.md
# Multi-Lane Serial Audio Receiver with Channel Crossbar

This block takes up to four serial audio data lines that share one bit clock and one word-select line and turns each line into a left and a right sample. All three common justifications are supported: standard I2S, left-justified and right-justified. The sample word width can be set from 16 to 24 bits, and the frame can be 32 or 64 bit clocks long. The bit clock and word select reach the block as ordinary inputs. The block samples them with its own system clock, which must run at least four times faster than the bit clock.

Once a frame is complete, a programmable crossbar picks any of the eight recovered channels for each of eight output slots. The slots form four left/right pairs, one pair per downstream subpacket. The crossbar loads all eight slots together and raises a one-cycle valid strobe. A change to the framing setup makes the receiver resynchronize, and the settings of the receive path can be changed while it runs.

Top module: `i2s_multi_rx`

## Requirements
- R1: With `fmt` = 2'b10 (left-justified), the MSB of each word is on the first bit clock of its half-frame. A half-frame starts at the bit clock on which `ws` changes level.
- R2: With `fmt` = 2'b00 (standard I2S), `ws` changes one bit clock before the MSB. The MSB is therefore on the second bit clock after the `ws` change.
- R3: With `fmt` = 2'b01 (right-justified), the LSB is on the last bit clock of the half-frame. Earlier bits outside the word are ignored.
- R4: `width` values below 16 act as 16 and values above 24 act as 24. Each sample is left-aligned in 24 bits with its low bits zero, and bits after the word are ignored.
- R5: `frame64` = 1 gives 32 bit clocks per channel and 0 gives 16. The effective width never exceeds the half-frame length.
- R6: `ws` low marks the left channel and `ws` high marks the right channel. All lines are sampled where `bclk` rises.
- R7: `slot_sel` holds eight 3-bit fields, where field s is at bits [3s+2:3s]. Field s picks channel 2·lane + (0 for left, 1 for right) for slot s. Slot s is output on `slot_data[24s+23:24s]`, and the slot order is pair0 L, pair0 R, pair1 L, and so on. A field value of s gives the identity mapping.
- R8: A lane whose `lane_en` bit is 0 contributes zero samples.
- R9: `slot_valid` pulses for one cycle per frame, two system clocks after the edge that samples the bit-clock rise carrying the right channel's last captured bit. It does not pulse when `lane_en` is all zero.
- R10: `fmt` = 2'b11 produces no samples and no valid strobe.
- R11: Any change of `fmt`, `width` or `frame64` stops capture until the next `ws` change, counted in the new format.
- R12: `slot_data` holds its value between valid strobes and is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock |
| ws | input | 1 | Word select (low = left) |
| sd | input | 4 | Serial data, one bit per lane |
| fmt | input | 2 | Justification: 00 I2S, 01 right, 10 left, 11 none |
| width | input | 5 | Sample word width in bits |
| frame64 | input | 1 | 1 = 64 bit clocks per frame, 0 = 32 |
| lane_en | input | 4 | Per-lane enable |
| slot_sel | input | 24 | Eight 3-bit channel selects, one per slot |
| slot_data | output | 192 | Eight 24-bit slot samples |
| slot_valid | output | 1 | One-cycle strobe when slots update |

## Verification
A wrong bit counter or a wrong lock flag shows up as soon as one frame is done. Either the valid strobe lands in the wrong system cycle, or a slot holds a shifted or mis-masked word. A wrong crossbar select or a wrong lane enable corrupts one slot at the next strobe. A slot register that is loaded outside the strobe shows up in the first cycle in which the held value differs from the one last delivered. The bench therefore compares the strobe and all 192 output bits on every system clock against a model built from the bits it sent.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'b00,
        FMT_RJ   = 2'b01,
        FMT_LJ   = 2'b10,
        FMT_NONE = 2'b11
    } rx_fmt_e;

    localparam int HALF_SHORT = 16;
    localparam int HALF_LONG  = 32;
    localparam int IDX_W      = 6;

endpackage

// File: rtl/i2s_frame_tracker.sv
module i2s_frame_tracker
    import i2s_rx_pkg::*;
#(
    parameter int MAXW  = 24,
    parameter int MINW  = 16,
    parameter int WBITS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_in,
    input  logic             ws_in,
    input  logic [1:0]       fmt,
    input  logic [WBITS-1:0] width,
    input  logic             frame64,
    output logic             tick,
    output logic             cap_left,
    output logic             cap_right,
    output logic [WBITS-1:0] weff,
    output logic             frame_done
);

    typedef struct packed {
        logic             bclk_prev;
        logic             ws_t1;
        logic             wse;
        logic             locked;
        logic [IDX_W-1:0] idx;
        logic [1:0]       fmt;
        logic [WBITS-1:0] width;
        logic             frame64;
        logic             done;
    } trk_t;

    localparam trk_t TRK_RST = '{
        bclk_prev: 1'b0, ws_t1: 1'b1, wse: 1'b1, locked: 1'b0,
        idx: '1, fmt: 2'b00, width: '0, frame64: 1'b0, done: 1'b0
    };

    trk_t st_q, st_d;

    logic [IDX_W-1:0] half_len, wclamp, weff_w, pos;
    logic             cfg_chg, ws_eff, ws_edge, live, hit, cap;

    // Effective width: clamp to [MINW, MAXW], then to the half-frame
    always_comb begin
        half_len = frame64 ? IDX_W'(HALF_LONG) : IDX_W'(HALF_SHORT);
        wclamp   = IDX_W'(width);
        if (wclamp < IDX_W'(MINW)) wclamp = IDX_W'(MINW);
        if (wclamp > IDX_W'(MAXW)) wclamp = IDX_W'(MAXW);
        weff_w   = (wclamp > half_len) ? half_len : wclamp;
    end

    assign weff = weff_w[WBITS-1:0];

    always_comb begin
        st_d    = st_q;
        cfg_chg = (fmt != st_q.fmt) || (width != st_q.width) || (frame64 != st_q.frame64);
        tick    = bclk_in & ~st_q.bclk_prev;
        // standard I2S is left-justified with word select delayed by one bit
        ws_eff  = (fmt == FMT_I2S) ? st_q.ws_t1 : ws_in;
        ws_edge = ws_eff != st_q.wse;
        if (ws_edge)
            pos = '0;
        else if (st_q.idx == '1)
            pos = st_q.idx;
        else
            pos = st_q.idx + 1'b1;
        live = (st_q.locked | ws_edge) & ~cfg_chg & (fmt != FMT_NONE);
        if (fmt == FMT_RJ)
            hit = (pos == half_len - 1'b1);
        else
            hit = (pos == weff_w - 1'b1);
        cap       = tick & live & hit;
        cap_left  = cap & ~ws_eff;
        cap_right = cap & ws_eff;

        st_d.bclk_prev = bclk_in;
        st_d.done      = cap_right;
        if (tick) begin
            st_d.ws_t1 = ws_in;
            st_d.wse   = ws_eff;
            st_d.idx   = pos;
            if (ws_edge) st_d.locked = 1'b1;
        end
        if (cfg_chg) begin
            st_d.locked  = 1'b0;
            st_d.fmt     = fmt;
            st_d.width   = width;
            st_d.frame64 = frame64;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TRK_RST;
        else        st_q <= st_d;
    end

    assign frame_done = st_q.done;

    // R11: a setup change always drops lock for the following cycle
    p_resync_unlock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> !st_q.locked);

    // R4, R5: effective width stays inside the legal range and the half-frame
    p_weff_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (weff >= WBITS'(MINW)) && (weff <= WBITS'(MAXW)) && (IDX_W'(weff) <= half_len));

    // R6: one capture cannot be both channels
    p_cap_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_left, cap_right}));

endmodule

// File: rtl/i2s_lane_deser.sv
module i2s_lane_deser #(
    parameter int MAXW  = 24,
    parameter int WBITS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cap_left,
    input  logic             cap_right,
    input  logic [WBITS-1:0] weff,
    input  logic             en,
    input  logic             sd,
    output logic [MAXW-1:0]  left,
    output logic [MAXW-1:0]  right
);

    typedef struct packed {
        logic [MAXW-1:0] sr;
        logic [MAXW-1:0] left;
        logic [MAXW-1:0] right;
    } lane_t;

    lane_t ln_q, ln_d;

    logic [MAXW-1:0] sr_new, keep, aligned;

    always_comb begin
        sr_new = {ln_q.sr[MAXW-2:0], sd};
        for (int i = 0; i < MAXW; i++)
            keep[i] = (i < int'(weff));
        aligned = (sr_new & keep) << (MAXW - int'(weff));

        ln_d = ln_q;
        if (tick)      ln_d.sr    = sr_new;
        if (cap_left)  ln_d.left  = aligned;
        if (cap_right) ln_d.right = aligned;
        if (!en) begin
            ln_d.left  = '0;
            ln_d.right = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign left  = ln_q.left;
    assign right = ln_q.right;

    // R8: a disabled lane reads as zero on the next cycle
    p_disabled_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (left == '0) && (right == '0));

endmodule

// File: rtl/i2s_slot_xbar.sv
module i2s_slot_xbar #(
    parameter int NCH  = 8,
    parameter int SW   = 24,
    parameter int SELW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH*SW-1:0]   ch_flat,
    input  logic [NCH*SELW-1:0] sel_flat,
    input  logic                load,
    output logic [NCH*SW-1:0]   slots_flat,
    output logic                valid
);

    typedef struct packed {
        logic [NCH-1:0][SW-1:0] slots;
        logic                   valid;
    } xb_t;

    xb_t xb_q, xb_d;

    logic [NCH-1:0][SW-1:0]   ch;
    logic [NCH-1:0][SELW-1:0] sel;

    assign ch  = ch_flat;
    assign sel = sel_flat;

    always_comb begin
        xb_d       = xb_q;
        xb_d.valid = load;
        if (load) begin
            for (int s = 0; s < NCH; s++) begin
                if (int'(sel[s]) < NCH) xb_d.slots[s] = ch[sel[s]];
                else                    xb_d.slots[s] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) xb_q <= '0;
        else        xb_q <= xb_d;
    end

    assign slots_flat = xb_q.slots;
    assign valid      = xb_q.valid;

    // R9: the strobe is a single-cycle pulse
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R12: slots are held when no frame completes
    p_slots_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(slots_flat));

endmodule

// File: rtl/i2s_multi_rx.sv
module i2s_multi_rx
    import i2s_rx_pkg::*;
#(
    parameter int NLANES = 4,
    parameter int MAXW   = 24,
    parameter int MINW   = 16,
    parameter int WBITS  = 5,
    localparam int NCH   = 2 * NLANES,
    localparam int SELW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk,
    input  logic                 ws,
    input  logic [NLANES-1:0]    sd,
    input  logic [1:0]           fmt,
    input  logic [WBITS-1:0]     width,
    input  logic                 frame64,
    input  logic [NLANES-1:0]    lane_en,
    input  logic [NCH*SELW-1:0]  slot_sel,
    output logic [NCH*MAXW-1:0]  slot_data,
    output logic                 slot_valid
);

    logic             tick, cap_left, cap_right, frame_done;
    logic [WBITS-1:0] weff;
    logic [NCH*MAXW-1:0] ch_flat;

    i2s_frame_tracker #(.MAXW(MAXW), .MINW(MINW), .WBITS(WBITS)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_in   (bclk),
        .ws_in     (ws),
        .fmt       (fmt),
        .width     (width),
        .frame64   (frame64),
        .tick      (tick),
        .cap_left  (cap_left),
        .cap_right (cap_right),
        .weff      (weff),
        .frame_done(frame_done)
    );

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic [MAXW-1:0] l_left, l_right;
        i2s_lane_deser #(.MAXW(MAXW), .WBITS(WBITS)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .cap_left (cap_left),
            .cap_right(cap_right),
            .weff     (weff),
            .en       (lane_en[l]),
            .sd       (sd[l]),
            .left     (l_left),
            .right    (l_right)
        );
        assign ch_flat[(2*l)*MAXW   +: MAXW] = l_left;
        assign ch_flat[(2*l+1)*MAXW +: MAXW] = l_right;
    end

    i2s_slot_xbar #(.NCH(NCH), .SW(MAXW), .SELW(SELW)) u_xbar (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_flat   (ch_flat),
        .sel_flat  (slot_sel),
        .load      (frame_done & (|lane_en)),
        .slots_flat(slot_data),
        .valid     (slot_valid)
    );

    // R9: no strobe while every lane was disabled
    p_valid_needs_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> (|$past(lane_en)));

endmodule

// File: tb/tb_i2s_multi_rx.sv
module tb_i2s_multi_rx;

    localparam int NL   = 4;
    localparam int MAXW = 24;
    localparam int NCH  = 8;
    localparam int SELW = 3;
    localparam int CLKP = 10;
    localparam int VW   = NCH * MAXW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bclk = 1'b0;
    logic            ws = 1'b1;
    logic [NL-1:0]   sd = '0;
    logic [1:0]      fmt = 2'b10;
    logic [4:0]      width = 5'd24;
    logic            frame64 = 1'b1;
    logic [NL-1:0]   lane_en = '1;
    logic [NCH*SELW-1:0] slot_sel;
    logic [VW-1:0]   slot_data;
    logic            slot_valid;

    i2s_multi_rx dut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .ws(ws), .sd(sd),
        .fmt(fmt), .width(width), .frame64(frame64), .lane_en(lane_en),
        .slot_sel(slot_sel), .slot_data(slot_data), .slot_valid(slot_valid)
    );

    always #(CLKP/2) clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    string tag = "R12";
    bit    run_chk = 1'b0;

    int         eq_cyc[$];
    logic [VW-1:0] eq_val[$];
    logic [VW-1:0] held = '0;

    bit            q_ws[$];
    logic [NL-1:0] q_sd[$];
    int            cap_idx[$];
    logic [VW-1:0] cap_val[$];
    logic [MAXW-1:0] mdl_l[NL];
    logic [MAXW-1:0] mdl_r[NL];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void check(bit ok, string req, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp);
        end
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (run_chk) begin
            if (eq_cyc.size() > 0 && eq_cyc[0] == cyc) begin
                check(slot_valid == 1'b1, {tag, "/R9 valid"}, VW'(slot_valid), VW'(1));
                check(slot_data == eq_val[0], tag, slot_data, eq_val[0]);
                held = eq_val[0];
                void'(eq_cyc.pop_front());
                void'(eq_val.pop_front());
            end else begin
                check(slot_valid == 1'b0, {tag, "/R9 no valid"}, VW'(slot_valid), VW'(0));
                check(slot_data == held, {tag, "/R12 hold"}, slot_data, held);
            end
        end
    end

    function automatic int eff_w(int w, int half);
        int e = w;
        if (e < 16) e = 16;
        if (e > 24) e = 24;
        if (e > half) e = half;
        return e;
    endfunction

    function automatic logic [MAXW-1:0] topbits(logic [MAXW-1:0] v, int w);
        logic [MAXW-1:0] m = ~((24'h1 << (MAXW - w)) - 24'h1);
        return v & m;
    endfunction

    function automatic logic [VW-1:0] slots_now();
        logic [VW-1:0] r = '0;
        for (int s = 0; s < NCH; s++) begin
            int c = int'(slot_sel[s*SELW +: SELW]);
            r[s*MAXW +: MAXW] = (c % 2) ? mdl_r[c/2] : mdl_l[c/2];
        end
        return r;
    endfunction

    // Build one burst: a prefix bit, then nfr frames; chg >= 0 marks a width change
    task automatic build(input logic [1:0] f, input int wsel, input bit long, input int nfr,
                         input int chg, input int wsel2);
        int H = long ? 32 : 16;
        int w1 = eff_w(wsel, H);
        int w2 = eff_w(wsel2, H);
        int total = 1 + nfr * 2 * H;
        bit lab[$];
        logic [MAXW-1:0] v [16][2][NL];
        q_ws.delete(); q_sd.delete(); cap_idx.delete(); cap_val.delete();
        for (int fr = 0; fr < nfr; fr++)
            for (int h = 0; h < 2; h++)
                for (int l = 0; l < NL; l++)
                    v[fr][h][l] = MAXW'($urandom);
        lab.push_back(1'b1);
        q_sd.push_back('0);
        for (int fr = 0; fr < nfr; fr++) begin
            for (int h = 0; h < 2; h++) begin
                int hs = 1 + fr * 2 * H + h * H;
                int wh = (chg >= 0 && hs >= chg) ? w2 : w1;
                for (int p = 0; p < H; p++) begin
                    logic [NL-1:0] b;
                    for (int l = 0; l < NL; l++) begin
                        if (f == 2'b01)
                            b[l] = (p >= H - wh) ? v[fr][h][l][MAXW-1-(p-(H-wh))] : 1'b1;
                        else
                            b[l] = (p < MAXW && p < H) ? v[fr][h][l][MAXW-1-p] : 1'b0;
                    end
                    lab.push_back(h[0]);
                    q_sd.push_back(b);
                end
            end
        end
        for (int k = 0; k < total; k++)
            q_ws.push_back((f == 2'b00) ? ((k + 1 < total) ? lab[k+1] : 1'b1) : lab[k]);
        for (int l = 0; l < NL; l++)
            if (!lane_en[l]) begin mdl_l[l] = '0; mdl_r[l] = '0; end
        if (f == 2'b11) return;
        for (int fr = 0; fr < nfr; fr++) begin
            for (int h = 0; h < 2; h++) begin
                int hs = 1 + fr * 2 * H + h * H;
                int c_old = hs + ((f == 2'b01) ? H - 1 : w1 - 1);
                int wu = 0;
                int ci = -1;
                if (chg < 0 || c_old < chg) begin wu = w1; ci = c_old; end
                else if (hs >= chg) begin wu = w2; ci = hs + ((f == 2'b01) ? H - 1 : w2 - 1); end
                if (ci >= 0) begin
                    for (int l = 0; l < NL; l++) begin
                        logic [MAXW-1:0] e = lane_en[l] ? topbits(v[fr][h][l], wu) : '0;
                        if (h == 0) mdl_l[l] = e; else mdl_r[l] = e;
                    end
                    if (h == 1 && lane_en != '0) begin
                        cap_idx.push_back(ci);
                        cap_val.push_back(slots_now());
                    end
                end
            end
        end
    endtask

    task automatic play(input int chg, input logic [4:0] w2);
        for (int k = 0; k < q_ws.size(); k++) begin
            @(negedge clk);
            bclk = 1'b0; ws = q_ws[k]; sd = q_sd[k];
            if (k == chg) width = w2;
            @(negedge clk);
            @(negedge clk);
            bclk = 1'b1;
            if (cap_idx.size() > 0 && cap_idx[0] == k) begin
                eq_cyc.push_back(cyc + 2);
                eq_val.push_back(cap_val[0]);
                void'(cap_idx.pop_front());
                void'(cap_val.pop_front());
            end
            @(negedge clk);
        end
        @(negedge clk);
        bclk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic burst(input string t, input logic [1:0] f, input int w, input bit long,
                         input int nfr, input int chg, input int w2);
        @(negedge clk);
        tag = t; fmt = f; width = 5'(w); frame64 = long;
        repeat (3) @(negedge clk);
        build(f, w, long, nfr, chg, w2);
        play(chg, 5'(w2));
    endtask

    function automatic logic [NCH*SELW-1:0] identity_sel();
        logic [NCH*SELW-1:0] r;
        for (int s = 0; s < NCH; s++) r[s*SELW +: SELW] = SELW'(s);
        return r;
    endfunction

    initial begin
        #(CLKP * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        slot_sel = identity_sel();
        for (int l = 0; l < NL; l++) begin mdl_l[l] = '0; mdl_r[l] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state of the outputs
        check(slot_valid == 1'b0 && slot_data == '0, "R12 reset", slot_data, '0);
        run_chk = 1'b1;

        burst("R1 left-justified",  2'b10, 24, 1'b1, 3, -1, 0);
        burst("R2 standard I2S",    2'b00, 24, 1'b1, 3, -1, 0);
        burst("R3 right-justified", 2'b01, 20, 1'b1, 3, -1, 0);
        burst("R6 polarity",        2'b00, 18, 1'b1, 2, -1, 0);
        burst("R4 width below 16",  2'b10, 10, 1'b1, 2, -1, 0);
        burst("R4 width above 24",  2'b10, 30, 1'b1, 2, -1, 0);
        burst("R4 right width 17",  2'b01, 17, 1'b1, 2, -1, 0);
        burst("R5 short left",      2'b10, 24, 1'b0, 3, -1, 0);
        burst("R5 short I2S",       2'b00, 16, 1'b0, 3, -1, 0);
        burst("R5 short right",     2'b01, 20, 1'b0, 3, -1, 0);

        for (int s = 0; s < NCH; s++) slot_sel[s*SELW +: SELW] = SELW'(NCH - 1 - s);
        burst("R7 reversed map",    2'b10, 22, 1'b1, 2, -1, 0);
        for (int s = 0; s < NCH; s++) slot_sel[s*SELW +: SELW] = SELW'(5);
        burst("R7 broadcast map",   2'b00, 24, 1'b1, 2, -1, 0);
        slot_sel = identity_sel();

        lane_en = 4'b0101;
        burst("R8 lanes masked",    2'b10, 24, 1'b1, 2, -1, 0);
        lane_en = 4'b0000;
        burst("R9 all lanes off",   2'b10, 24, 1'b1, 2, -1, 0);
        lane_en = 4'b1111;
        burst("R10 unsupported",    2'b11, 24, 1'b1, 2, -1, 0);

        // R11: width changes in the middle of frame 1's left half
        burst("R11 resync",         2'b10, 24, 1'b1, 3, 1 + 64 + 16, 16);

        repeat (20) @(negedge clk);
        if (eq_cyc.size() != 0) begin
            checks++; fails++;
            $display("FAIL R9 %0d strobes not seen, expected 0 pending", eq_cyc.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule